// File: doc/BRIEF.md
# Key-Protected GPIO Pad Controller

This block is a register bank that controls up to 64 general-purpose pads (50 by default) from a 32-bit register bus. The bus has a byte address, write data, a write strobe and read data that is always valid. Each pad has an 8-bit pad-control byte and a 4-bit pin nibble. The pad-control byte holds the pull-up, input enable, drive strength, function select and power bits. The pin nibble holds read-zero, output mode and interrupt edge. Both of these are write-protected: a write to them is accepted only while a key register holds the unlock word. Software writes the key, changes the configuration, then writes any other value to the key to relock.

The output-data and output-enable registers each have write-one-to-set and write-one-to-clear aliases, so one pin can change without a read-modify-write. The pad inputs pass through a two-flop synchronizer. The synchronized levels feed an input read register and a per-pin edge detector. The edge detector sets sticky interrupt status bits, and a single interrupt line is the OR of the enabled status bits. The pad-control byte is passed straight to the pad as control bits. Drive strength, pulls and power switching are not modelled.

Top module: `gpio_keyed_bank`

## Requirements
- R1: After reset every register reads 0, `pad_oe`, `pad_out` and `pad_ctrl` are all 0, and `irq` is 0.
- R2: A write of 0x73 to the key register at 0x60 unlocks, and the key register then reads 1. A write of any other value locks it, and it then reads 0.
- R3: While the bank is locked, writes to the pad-control words and pin words are dropped: readback and `pad_ctrl` keep their values.
- R4: Pad n's control byte sits in the word at byte address 4*(n/4), at bits 8*(n%4)+7 down to 8*(n%4). It appears unchanged on `pad_ctrl[8n+7:8n]`. Within the byte, bits 5:3 are the function select.
- R5: Pin n's nibble sits in the word at 0x40+4*(n/8), at bits 4*(n%8)+3 down to 4*(n%8). Nibble bit 0 is read-zero, bits 2:1 are the output mode (0 off, 1 push-pull, 2 open-drain, 3 tri-state) and bit 3 is the interrupt edge (1 falling, 0 rising). Words read back, and bits with no pin read 0.
- R6: Every per-pin bit register keeps pin n in word n/32 (byte offset 4 for pins 32 and up) at bit n%32. Output data is at 0x78, with set alias 0x80 and clear alias 0x88. Output enable is at 0x90, with set alias 0x98 and clear alias 0xA0. A 1 in a set or clear write sets or clears that bit, and a 0 leaves it unchanged.
- R7: For a pin whose function select is 3, the pad drives as follows. Push-pull: `pad_oe`=1 and `pad_out`=data. Open-drain: `pad_oe`=NOT data and `pad_out`=0. Tri-state: `pad_oe`=enable bit and `pad_out`=data. Off: both 0.
- R8: A pin whose function select is not 3 has `pad_oe`=0 and `pad_out`=0, whatever its mode and data.
- R9: The input register at 0x70 shows `pad_in` two clocks after it changes. A pin with read-zero set reads 0.
- R10: A synchronized edge that matches the pin's edge bit sets its status bit (status at 0xB8) on the third clock after the pad changes. An edge of the other direction does nothing.
- R11: A 1 written to 0xC0 sets a status bit, and a 1 written to 0xC8 clears it. `irq` is high exactly when a status bit is set whose interrupt enable (0xB0) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | NUM_PADS | Pad input levels, asynchronous |
| pad_out | output | NUM_PADS | Pad output levels |
| pad_oe | output | NUM_PADS | Pad output enables |
| pad_ctrl | output | 8*NUM_PADS | Pad-control bytes, pad n at bits 8n+7:8n |
| irq | output | 1 | Combined interrupt |

## Verification
A corrupted configuration or data bit shows up on `pad_oe`, `pad_out` or `pad_ctrl` in the cycle after the write that should have set it, because those outputs are decoded from the registers with no further stage. A broken key gate shows up as changed readback right after a write made while locked. A fault in the synchronizer or edge logic only shows up at the input read register or in the status bits, two and three clocks after a pad change. The bench therefore waits those cycles before it compares. The sweeps cover every pin and every combination of mode, data and enable, so a wrong pin mapping or a wrong mode decode cannot hide behind the one pin that happens to be tested.

// File: rtl/gpio_kb_pkg.sv
package gpio_kb_pkg;

    localparam int ADDR_W = 8;
    typedef logic [ADDR_W-1:0] addr_t;

    // byte addresses of the register groups
    localparam addr_t ADR_PAD  = 8'h00;  // pad control words, four pads each
    localparam addr_t ADR_PIN  = 8'h40;  // pin nibble words, eight pins each
    localparam addr_t ADR_KEY  = 8'h60;
    localparam addr_t ADR_IN   = 8'h70;
    localparam addr_t ADR_DAT  = 8'h78;
    localparam addr_t ADR_DSET = 8'h80;
    localparam addr_t ADR_DCLR = 8'h88;
    localparam addr_t ADR_OEN  = 8'h90;
    localparam addr_t ADR_OSET = 8'h98;
    localparam addr_t ADR_OCLR = 8'hA0;
    localparam addr_t ADR_IEN  = 8'hB0;
    localparam addr_t ADR_IST  = 8'hB8;
    localparam addr_t ADR_ISET = 8'hC0;
    localparam addr_t ADR_ICLR = 8'hC8;

    localparam logic [2:0] FUNC_GPIO = 3'd3;

    typedef enum logic [1:0] {
        OM_OFF       = 2'd0,
        OM_PUSHPULL  = 2'd1,
        OM_OPENDRAIN = 2'd2,
        OM_TRISTATE  = 2'd3
    } out_mode_e;

    typedef struct packed {
        logic      fall_edge;
        out_mode_e mode;
        logic      rd_zero;
    } pin_cfg_t;

    typedef struct packed {
        logic [1:0] power;
        logic [2:0] func;
        logic       high_drive;
        logic       in_en;
        logic       pull_up;
    } pad_cfg_t;

    // word of a one-bit-per-pin register that holds pin n
    function automatic logic bit_hit(addr_t a, addr_t base, int n);
        return a == base + addr_t'(4 * (n / 32));
    endfunction

    function automatic logic pad_hit(addr_t a, int n);
        return a == ADR_PAD + addr_t'(4 * (n / 4));
    endfunction

    function automatic logic pin_hit(addr_t a, int n);
        return a == ADR_PIN + addr_t'(4 * (n / 8));
    endfunction

endpackage

// File: rtl/gpio_kb_cfg.sv
module gpio_kb_cfg
    import gpio_kb_pkg::*;
#(
    parameter int          NUM_PADS  = 50,
    parameter logic [31:0] KEY_VALUE = 32'h73
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  addr_t                 addr,
    input  logic [31:0]           wdata,
    output logic                  key_open,
    output logic [8*NUM_PADS-1:0] pad_q,
    output logic [4*NUM_PADS-1:0] pin_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            key_open <= 1'b0;
            pad_q    <= '0;
            pin_q    <= '0;
        end else if (we) begin
            if (addr == ADR_KEY)
                key_open <= (wdata == KEY_VALUE);
            if (key_open) begin
                for (int n = 0; n < NUM_PADS; n++) begin
                    if (pad_hit(addr, n))
                        pad_q[8*n +: 8] <= wdata[8*(n%4) +: 8];
                    if (pin_hit(addr, n))
                        pin_q[4*n +: 4] <= wdata[4*(n%8) +: 4];
                end
            end
        end
    end

    p_lock_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !key_open |=> ($stable(pad_q) && $stable(pin_q)));

    p_relock_r2: assert property (@(posedge clk) disable iff (rst)
        (we && addr == ADR_KEY && wdata != KEY_VALUE) |=> !key_open);

endmodule

// File: rtl/gpio_kb_bitreg.sv
module gpio_kb_bitreg
    import gpio_kb_pkg::*;
#(
    parameter int    NUM_PADS = 50,
    parameter addr_t BASE     = ADR_DAT,
    parameter bit    ALIASES  = 1'b1,
    parameter addr_t SET_BASE = ADR_DSET,
    parameter addr_t CLR_BASE = ADR_DCLR
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  addr_t               addr,
    input  logic [31:0]         wdata,
    output logic [NUM_PADS-1:0] q
);

    logic [NUM_PADS-1:0] wr_m, set_m, clr_m, wbits, nxt;

    always_comb begin
        for (int n = 0; n < NUM_PADS; n++) begin
            wr_m[n]  = we && bit_hit(addr, BASE, n);
            wbits[n] = wdata[n%32];
        end
    end

    generate
        if (ALIASES) begin : g_alias
            always_comb begin
                for (int n = 0; n < NUM_PADS; n++) begin
                    set_m[n] = we && bit_hit(addr, SET_BASE, n) && wdata[n%32];
                    clr_m[n] = we && bit_hit(addr, CLR_BASE, n) && wdata[n%32];
                end
            end
        end else begin : g_plain
            assign set_m = '0;
            assign clr_m = '0;
        end
    endgenerate

    assign nxt = (((q & ~wr_m) | (wbits & wr_m)) | set_m) & ~clr_m;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

endmodule

// File: rtl/gpio_kb_drive.sv
module gpio_kb_drive
    import gpio_kb_pkg::*;
#(
    parameter int NUM_PADS = 50
) (
    input  logic [3*NUM_PADS-1:0] func,
    input  logic [2*NUM_PADS-1:0] mode,
    input  logic [NUM_PADS-1:0]   dat,
    input  logic [NUM_PADS-1:0]   oen,
    output logic [NUM_PADS-1:0]   pad_out,
    output logic [NUM_PADS-1:0]   pad_oe
);

    for (genvar n = 0; n < NUM_PADS; n++) begin : g_pin
        out_mode_e m;
        logic      mine;
        assign m    = out_mode_e'(mode[2*n +: 2]);
        assign mine = (func[3*n +: 3] == FUNC_GPIO);
        always_comb begin
            pad_out[n] = 1'b0;
            pad_oe[n]  = 1'b0;
            if (mine) begin
                unique case (m)
                    OM_PUSHPULL:  begin pad_out[n] = dat[n]; pad_oe[n] = 1'b1;    end
                    OM_OPENDRAIN: begin pad_out[n] = 1'b0;   pad_oe[n] = ~dat[n]; end
                    OM_TRISTATE:  begin pad_out[n] = dat[n]; pad_oe[n] = oen[n];  end
                    default:      begin pad_out[n] = 1'b0;   pad_oe[n] = 1'b0;    end
                endcase
            end
        end
    end

endmodule

// File: rtl/gpio_kb_irq.sv
module gpio_kb_irq #(
    parameter int NUM_PADS = 50
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PADS-1:0] pad_in,
    input  logic [NUM_PADS-1:0] fall_sel,
    input  logic [NUM_PADS-1:0] irq_en,
    input  logic [NUM_PADS-1:0] st_set,
    input  logic [NUM_PADS-1:0] st_clr,
    output logic [NUM_PADS-1:0] sync_in,
    output logic [NUM_PADS-1:0] status,
    output logic                irq
);

    logic [NUM_PADS-1:0] meta, last, edge_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta    <= '0;
            sync_in <= '0;
            last    <= '0;
        end else begin
            meta    <= pad_in;
            sync_in <= meta;
            last    <= sync_in;
        end
    end

    // rising: new 1 over old 0; falling: new 0 over old 1
    assign edge_hit = (fall_sel & last & ~sync_in) | (~fall_sel & sync_in & ~last);

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~st_clr) | st_set | edge_hit;
    end

    assign irq = |(status & irq_en);

    for (genvar n = 0; n < NUM_PADS; n++) begin : g_chk
        p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
            (status[n] && !st_clr[n]) |=> status[n]);
    end

endmodule

// File: rtl/gpio_keyed_bank.sv
module gpio_keyed_bank
    import gpio_kb_pkg::*;
#(
    parameter int          NUM_PADS  = 50,
    parameter logic [31:0] KEY_VALUE = 32'h73
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [7:0]            bus_addr,
    input  logic [31:0]           bus_wdata,
    input  logic                  bus_we,
    output logic [31:0]           bus_rdata,
    input  logic [NUM_PADS-1:0]   pad_in,
    output logic [NUM_PADS-1:0]   pad_out,
    output logic [NUM_PADS-1:0]   pad_oe,
    output logic [8*NUM_PADS-1:0] pad_ctrl,
    output logic                  irq
);

    logic                  key_open;
    logic [8*NUM_PADS-1:0] pad_q;
    logic [4*NUM_PADS-1:0] pin_q;
    logic [NUM_PADS-1:0]   dat, oen, ien, status, sync_in, in_rd;
    logic [NUM_PADS-1:0]   fall_sel, rd_zero, st_set, st_clr;
    logic [3*NUM_PADS-1:0] func;
    logic [2*NUM_PADS-1:0] mode;

    gpio_kb_cfg #(.NUM_PADS(NUM_PADS), .KEY_VALUE(KEY_VALUE)) i_cfg (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .key_open(key_open), .pad_q(pad_q), .pin_q(pin_q));

    gpio_kb_bitreg #(.NUM_PADS(NUM_PADS), .BASE(ADR_DAT), .ALIASES(1'b1),
                     .SET_BASE(ADR_DSET), .CLR_BASE(ADR_DCLR)) i_dat (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata), .q(dat));

    gpio_kb_bitreg #(.NUM_PADS(NUM_PADS), .BASE(ADR_OEN), .ALIASES(1'b1),
                     .SET_BASE(ADR_OSET), .CLR_BASE(ADR_OCLR)) i_oen (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata), .q(oen));

    gpio_kb_bitreg #(.NUM_PADS(NUM_PADS), .BASE(ADR_IEN), .ALIASES(1'b0),
                     .SET_BASE(ADR_IEN), .CLR_BASE(ADR_IEN)) i_ien (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata), .q(ien));

    always_comb begin
        for (int n = 0; n < NUM_PADS; n++) begin
            func[3*n +: 3] = pad_q[8*n+3 +: 3];
            mode[2*n +: 2] = pin_q[4*n+1 +: 2];
            fall_sel[n]    = pin_q[4*n+3];
            rd_zero[n]     = pin_q[4*n];
            st_set[n]      = bus_we && bit_hit(bus_addr, ADR_ISET, n) && bus_wdata[n%32];
            st_clr[n]      = bus_we && bit_hit(bus_addr, ADR_ICLR, n) && bus_wdata[n%32];
        end
    end

    gpio_kb_drive #(.NUM_PADS(NUM_PADS)) i_drive (
        .func(func), .mode(mode), .dat(dat), .oen(oen),
        .pad_out(pad_out), .pad_oe(pad_oe));

    gpio_kb_irq #(.NUM_PADS(NUM_PADS)) i_irq (
        .clk(clk), .rst(rst), .pad_in(pad_in), .fall_sel(fall_sel), .irq_en(ien),
        .st_set(st_set), .st_clr(st_clr), .sync_in(sync_in), .status(status), .irq(irq));

    assign in_rd    = sync_in & ~rd_zero;
    assign pad_ctrl = pad_q;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADR_KEY) bus_rdata[0] = key_open;
        for (int n = 0; n < NUM_PADS; n++) begin
            if (pad_hit(bus_addr, n))           bus_rdata[8*(n%4) +: 8] = pad_q[8*n +: 8];
            if (pin_hit(bus_addr, n))           bus_rdata[4*(n%8) +: 4] = pin_q[4*n +: 4];
            if (bit_hit(bus_addr, ADR_IN, n))   bus_rdata[n%32] = in_rd[n];
            if (bit_hit(bus_addr, ADR_DAT, n))  bus_rdata[n%32] = dat[n];
            if (bit_hit(bus_addr, ADR_OEN, n))  bus_rdata[n%32] = oen[n];
            if (bit_hit(bus_addr, ADR_IEN, n))  bus_rdata[n%32] = ien[n];
            if (bit_hit(bus_addr, ADR_IST, n))  bus_rdata[n%32] = status[n];
        end
    end

    for (genvar n = 0; n < NUM_PADS; n++) begin : g_gate
        p_func_gate_r8: assert property (@(posedge clk) disable iff (rst)
            (pad_q[8*n+3 +: 3] != FUNC_GPIO) |-> (!pad_oe[n] && !pad_out[n]));
        p_opendrain_low_r7: assert property (@(posedge clk) disable iff (rst)
            (pin_q[4*n+1 +: 2] == 2'd2) |-> !pad_out[n]);
    end

endmodule

// File: tb/test_gpio_keyed_bank.sv
module test_gpio_keyed_bank;

    localparam int N = 50;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_out, pad_oe;
    logic [8*N-1:0] pad_ctrl;
    logic          irq;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    gpio_keyed_bank #(.NUM_PADS(N)) i_gpio_keyed_bank (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_ctrl(pad_ctrl), .irq(irq));

    localparam logic [63:0] PINMASK = (64'd1 << N) - 64'd1;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd64(input logic [7:0] a, output logic [63:0] v);
        logic [31:0] lo, hi;
        rd(a, lo);
        rd(a + 8'd4, hi);
        v = {hi, lo};
    endtask

    task automatic wr64(input logic [7:0] a, input logic [63:0] v);
        wr(a, v[31:0]);
        wr(a + 8'd4, v[63:32]);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [31:0] r;
        logic [63:0] v, exp_oe, exp_out, pat;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(8'h60, r);    chk("R1 key", 64'(r), 64'd0);
        rd64(8'h78, v);  chk("R1 data", v, 64'd0);
        rd(8'h00, r);    chk("R1 padcfg", 64'(r), 64'd0);
        chk("R1 pad_oe", 64'(pad_oe), 64'd0);
        chk("R1 pad_out", 64'(pad_out), 64'd0);
        chk("R1 irq", 64'(irq), 64'd0);

        // R3 writes while locked are dropped
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h00, r);    chk("R3 locked pad word", 64'(r), 64'd0);
        rd(8'h40, r);    chk("R3 locked pin word", 64'(r), 64'd0);
        chk("R3 locked pad_ctrl", 64'(pad_ctrl[31:0]), 64'd0);

        // R2 key behaviour
        wr(8'h60, 32'h74); rd(8'h60, r); chk("R2 wrong key", 64'(r), 64'd0);
        wr(8'h60, 32'h73); rd(8'h60, r); chk("R2 unlock", 64'(r), 64'd1);

        // R4 pad byte n carries value n
        for (int w = 0; w < (N + 3) / 4; w++)
            wr(8'(4 * w), {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)});
        for (int n = 0; n < N; n++)
            chk("R4 pad_ctrl byte", 64'(pad_ctrl[8*n +: 8]), 64'(n));
        rd(8'h30, r); chk("R4 last pad word", 64'(r), 64'h0000_3130);
        for (int w = 0; w < (N + 3) / 4; w++) wr(8'(4 * w), 32'h1A1A_1A1A);

        // R5 pin word readback
        for (int w = 0; w < (N + 7) / 8; w++) wr(8'h40 + 8'(4 * w), 32'h9A3C_5E71 ^ 32'(w));
        for (int w = 0; w < (N + 7) / 8; w++) begin
            rd(8'h40 + 8'(4 * w), r);
            chk("R5 pin word", 64'(r), (w == 6) ? 64'h0000_0077 : 64'(32'h9A3C_5E71 ^ 32'(w)));
        end

        // R6 set and clear aliases
        pat = 64'h0002_A5F0_0F5A_3C69 & PINMASK;
        wr64(8'h78, pat);  rd64(8'h78, v); chk("R6 data write", v, pat);
        wr64(8'h80, 64'h0001_0000_0000_0006); rd64(8'h78, v);
        chk("R6 data set", v, pat | 64'h0001_0000_0000_0006);
        wr64(8'h88, 64'h0002_0000_0000_0009); rd64(8'h78, v);
        chk("R6 data clear", v, (pat | 64'h0001_0000_0000_0006) & ~64'h0002_0000_0000_0009);
        wr64(8'h90, pat);  wr64(8'h98, 64'h0000_0001_0000_0000);
        wr64(8'hA0, 64'h0000_0000_0000_0001); rd64(8'h90, v);
        chk("R6 oe set clear", v, (pat | 64'h0000_0001_0000_0000) & ~64'h1);

        // R7 every mode, data and enable combination on every pin
        for (int m = 0; m < 4; m++) begin
            for (int d = 0; d < 2; d++) begin
                for (int e = 0; e < 2; e++) begin
                    for (int w = 0; w < (N + 7) / 8; w++)
                        wr(8'h40 + 8'(4 * w), {8{1'b0, 2'(m), 1'b0}});
                    wr64(8'h78, d ? 64'hFFFF_FFFF_FFFF_FFFF : 64'd0);
                    wr64(8'h90, e ? 64'hFFFF_FFFF_FFFF_FFFF : 64'd0);
                    case (m)
                        1: begin exp_oe = PINMASK;                exp_out = d ? PINMASK : 64'd0; end
                        2: begin exp_oe = d ? 64'd0 : PINMASK;    exp_out = 64'd0; end
                        3: begin exp_oe = e ? PINMASK : 64'd0;    exp_out = d ? PINMASK : 64'd0; end
                        default: begin exp_oe = 64'd0;            exp_out = 64'd0; end
                    endcase
                    chk("R7 pad_oe", 64'(pad_oe), exp_oe);
                    chk("R7 pad_out", 64'(pad_out), exp_out);
                end
            end
        end

        // R8 pin 5 taken away from the GPIO function (mode push-pull, data 1)
        for (int w = 0; w < (N + 7) / 8; w++) wr(8'h40 + 8'(4 * w), 32'h2222_2222);
        wr(8'h04, 32'h1A1A_021A);
        chk("R8 pad_oe", 64'(pad_oe), PINMASK & ~64'h20);
        chk("R8 pad_out", 64'(pad_out), PINMASK & ~64'h20);

        // R3 relock, then a dropped write
        wr(8'h60, 32'h0); rd(8'h60, r); chk("R2 relock", 64'(r), 64'd0);
        wr(8'h04, 32'h1A1A_1A1A); rd(8'h04, r); chk("R3 relocked pad word", 64'(r), 64'h1A1A_021A);
        chk("R3 relocked pad_oe", 64'(pad_oe[5]), 64'd0);

        // R9 input path and read-zero
        pat = 64'h0003_1234_5678_9ABC & PINMASK;
        @(negedge clk); pad_in = pat[N-1:0];
        @(negedge clk); rd64(8'h70, v); chk("R9 not yet after one clock", v, 64'd0);
        @(negedge clk); rd64(8'h70, v); chk("R9 input after two clocks", v, pat);
        wr(8'h60, 32'h73);
        wr(8'h40, 32'h3333_3333);
        rd64(8'h70, v); chk("R9 read-zero", v, pat & ~64'hFF);

        // R10 edges: even pins rising, odd pins falling
        @(negedge clk); pad_in = '0;
        repeat (4) @(negedge clk);
        for (int w = 0; w < (N + 7) / 8; w++) wr(8'h40 + 8'(4 * w), 32'hA2A2_A2A2);
        wr64(8'hC8, 64'hFFFF_FFFF_FFFF_FFFF);
        wr64(8'hB0, 64'hFFFF_FFFF_FFFF_FFFF);
        rd64(8'hB8, v); chk("R10 cleared", v, 64'd0);
        chk("R11 irq low when clear", 64'(irq), 64'd0);
        @(negedge clk); pad_in = '1;
        @(negedge clk); @(negedge clk);
        rd64(8'hB8, v); chk("R10 no status after two clocks", v, 64'd0);
        @(negedge clk);
        rd64(8'hB8, v); chk("R10 rising edges", v, 64'h0001_5555_5555_5555);
        chk("R11 irq high", 64'(irq), 64'd1);
        wr64(8'hC8, 64'hFFFF_FFFF_FFFF_FFFF);
        @(negedge clk); pad_in = '0;
        repeat (4) @(negedge clk);
        rd64(8'hB8, v); chk("R10 falling edges", v, 64'h0002_AAAA_AAAA_AAAA);
        wr64(8'hC8, 64'hFFFF_FFFF_FFFF_FFFF);

        // R11 software set, enable gating, clear
        wr64(8'hB0, 64'h0);
        wr(8'hC4, 32'h0002_0000);
        rd64(8'hB8, v); chk("R11 soft set", v, 64'h0002_0000_0000_0000);
        chk("R11 irq masked", 64'(irq), 64'd0);
        wr(8'hB4, 32'h0002_0000);
        chk("R11 irq enabled", 64'(irq), 64'd1);
        wr(8'hCC, 32'h0000_0001);
        rd64(8'hB8, v); chk("R11 zero bits keep status", v, 64'h0002_0000_0000_0000);
        wr(8'hCC, 32'h0002_0000);
        chk("R11 irq after clear", 64'(irq), 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule